// File: doc/BRIEF.md
# ADC Input Multiplexer Frame Sequencer

This block walks an analog front-end multiplexer through a programmable list of input slots. The slots repeat as conversion frames. Each slot takes a select code from one of two register banks. Regular frames read the regular bank. One frame after a host request reads the alternate bank instead. The sequencer advances on a slow timing strobe of 32768 Hz. Each state of the list lasts a fixed number of strobe ticks.

For every state the block drives the multiplexer select code and a one-clock pulse that starts the conversion filter. For every frame it drives a one-clock pulse that launches a compute-engine pass. It also drives a reference-chop output and a flag that covers the whole alternate frame, so that downstream logic can fill in the samples the alternate selections displaced.

The host raises an alternate request as a short level, which may last a single clock. Only its rising edge counts. The request waits for the next frame boundary. A battery-monitor enable output is gated by a dedicated enable bit, so the battery is loaded only when software allows it.

Top module: `mux_frame_seq`

## Requirements
- R1: While reset is high and until the first state begins, `muxSel`, `firStart`, `cePass`, `chopOut`, `altFrame` and `battMonEn` are all 0.
- R2: Strobes are counted from the first strobe after reset. Every `TICKS_PER_STATE`-th strobe (the 1st, the 4th, the 7th and so on with the default of 3) begins a state. On the clock after that strobe, `muxSel` shows the code of the slot being started. Slots run 0, 1, … up to the effective length minus one, then wrap to 0. Slot n's code is bits [4n+3:4n] of the selected bank vector. `muxSel` changes at no other time.
- R3: A `frameLen` of 0 gives frames of one slot. A value above `NUM_SLOTS` (10) gives frames of `NUM_SLOTS` slots. Any other value gives exactly that many slots.
- R4: `firStart` is high for exactly the one clock after each state-beginning strobe, and at no other time.
- R5: `cePass` is high for the one clock after a state-beginning strobe that starts slot 0, and at no other time.
- R6: A rising edge of `altReq` (high in this clock, low in the previous clock) leaves the frame in progress unchanged. It marks one alternate frame as pending. The next frame that begins takes its codes from `altSelVec` and holds `altFrame` high throughout, even when that frame begins in the same clock as the edge. The frame after it returns to `regSelVec`. Holding `altReq` high produces no further alternate frames.
- R7: Several request edges that arrive before the same frame boundary produce exactly one alternate frame.
- R8: While `chopEn` is 0, `chopOut` is 0 from the following clock onward. While `chopEn` is 1, `chopOut` inverts in the clock where `cePass` rises.
- R9: `battMonEn` is high exactly when `battEn` is 1 and `muxSel` equals `BATT_CODE` (11 by default). It follows `battEn` with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tickStrobe | input | 1 | One-clock pulse at 32768 Hz |
| frameLen | input | 4 | Requested states per frame |
| regSelVec | input | NUM_SLOTS*CODE_W | Regular bank: slot n at bits [CODE_W*n +: CODE_W] |
| altSelVec | input | NUM_SLOTS*CODE_W | Alternate bank, same layout |
| altReq | input | 1 | Alternate-frame request, edge sensitive |
| chopEn | input | 1 | Reference-chop enable |
| battEn | input | 1 | Battery-monitor permission |
| muxSel | output | CODE_W | Current multiplexer select code |
| firStart | output | 1 | Conversion-filter start, one clock per state |
| cePass | output | 1 | Compute-engine launch, one clock per frame |
| chopOut | output | 1 | Reference-chop control |
| altFrame | output | 1 | High during an alternate frame |
| battMonEn | output | 1 | Battery-monitor enable |

## Verification
The hardest case to reach is a request edge that lands in the same clock as a frame boundary, or a second edge that arrives while a request is already pending. Both depend on the phase of the strobe counter, which cannot be seen from outside. The stimulus drives long runs of random strobes, random short and long request pulses, and random frame lengths, including 0 and values above the slot count. These runs reach both cases many times, and a bench model that tracks every clock checks each of them. Directed runs then count alternate frames after a double pulse and after a request held high for a long time, and count states per frame at the clamped lengths.

// File: rtl/mux_seq_pkg.sv
package mux_seq_pkg;
  // the frame-length field is four bits wide, so a slot index never needs more
  localparam int SLOT_IDX_W = 4;

  typedef struct packed {
    logic                  stateGo;  // a new state begins at this edge
    logic                  frameGo;  // that state is slot 0
    logic                  useAlt;   // the state reads the alternate bank
    logic [SLOT_IDX_W-1:0] slot;     // slot being started
  } seqStrobe_t;
endpackage

// File: rtl/mux_seq_bank.sv
module mux_seq_bank
  import mux_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 10,
  parameter int CODE_W    = 4,
  localparam int VEC_W    = NUM_SLOTS * CODE_W
) (
  input  logic [VEC_W-1:0]      selVec,
  input  logic [SLOT_IDX_W-1:0] slot,
  output logic [CODE_W-1:0]     code
);
  always_comb begin
    code = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (slot == SLOT_IDX_W'(i)) code = selVec[i*CODE_W +: CODE_W];
    end
  end
endmodule

// File: rtl/mux_seq_ctrl.sv
module mux_seq_ctrl
  import mux_seq_pkg::*;
#(
  parameter int NUM_SLOTS       = 10,
  parameter int TICKS_PER_STATE = 3,
  localparam int TICK_W = (TICKS_PER_STATE > 1) ? $clog2(TICKS_PER_STATE) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tickStrobe,
  input  logic                  altReq,
  input  logic [SLOT_IDX_W-1:0] frameLen,
  output seqStrobe_t            strb,
  output logic                  altFrame
);
  localparam logic [SLOT_IDX_W-1:0] MAX_LEN   = SLOT_IDX_W'(NUM_SLOTS);
  localparam logic [TICK_W-1:0]     TICK_LAST = TICK_W'(TICKS_PER_STATE - 1);

  logic [TICK_W-1:0]     tickCnt;
  logic [SLOT_IDX_W-1:0] nextSlot;
  logic [SLOT_IDX_W-1:0] effLen;
  logic                  altPrev;
  logic                  altPending;
  logic                  reqEdge;
  logic                  lastSlot;

  assign reqEdge = altReq & ~altPrev;

  always_comb begin
    if (frameLen == '0)          effLen = SLOT_IDX_W'(1);
    else if (frameLen > MAX_LEN) effLen = MAX_LEN;
    else                         effLen = frameLen;
  end

  assign lastSlot = ({1'b0, nextSlot} + 1'b1) >= {1'b0, effLen};

  always_comb begin
    strb.stateGo = tickStrobe && (tickCnt == '0);
    strb.frameGo = strb.stateGo && (nextSlot == '0);
    strb.useAlt  = strb.frameGo ? (altPending | reqEdge) : altFrame;
    strb.slot    = nextSlot;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tickCnt    <= '0;
      nextSlot   <= '0;
      altPrev    <= 1'b0;
      altPending <= 1'b0;
      altFrame   <= 1'b0;
    end else begin
      altPrev <= altReq;
      if (tickStrobe) begin
        tickCnt <= (tickCnt == TICK_LAST) ? '0 : tickCnt + 1'b1;
      end
      if (strb.stateGo) begin
        nextSlot <= lastSlot ? '0 : nextSlot + 1'b1;
      end
      if (strb.frameGo) begin
        altFrame   <= strb.useAlt;
        altPending <= 1'b0;
      end else if (reqEdge) begin
        altPending <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mux_seq_dp.sv
module mux_seq_dp
  import mux_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 10,
  parameter int CODE_W    = 4,
  parameter int BATT_CODE = 11,
  localparam int VEC_W    = NUM_SLOTS * CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strb,
  input  logic [VEC_W-1:0]  regSelVec,
  input  logic [VEC_W-1:0]  altSelVec,
  input  logic              chopEn,
  input  logic              battEn,
  output logic [CODE_W-1:0] muxSel,
  output logic              firStart,
  output logic              cePass,
  output logic              chopOut,
  output logic              battMonEn
);
  localparam logic [CODE_W-1:0] BATT_SEL = CODE_W'(BATT_CODE);

  logic [CODE_W-1:0] bankCode [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    mux_seq_bank #(
      .NUM_SLOTS(NUM_SLOTS),
      .CODE_W   (CODE_W)
    ) u_bank (
      .selVec(b == 0 ? regSelVec : altSelVec),
      .slot  (strb.slot),
      .code  (bankCode[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      muxSel   <= '0;
      firStart <= 1'b0;
      cePass   <= 1'b0;
      chopOut  <= 1'b0;
    end else begin
      firStart <= strb.stateGo;
      cePass   <= strb.frameGo;
      if (strb.stateGo) muxSel <= strb.useAlt ? bankCode[1] : bankCode[0];
      if (!chopEn)           chopOut <= 1'b0;
      else if (strb.frameGo) chopOut <= ~chopOut;
    end
  end

  assign battMonEn = battEn && (muxSel == BATT_SEL);
endmodule

// File: rtl/mux_frame_seq.sv
module mux_frame_seq
  import mux_seq_pkg::*;
#(
  parameter int NUM_SLOTS       = 10,
  parameter int CODE_W          = 4,
  parameter int TICKS_PER_STATE = 3,
  parameter int BATT_CODE       = 11
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        tickStrobe,
  input  logic [3:0]                  frameLen,
  input  logic [NUM_SLOTS*CODE_W-1:0] regSelVec,
  input  logic [NUM_SLOTS*CODE_W-1:0] altSelVec,
  input  logic                        altReq,
  input  logic                        chopEn,
  input  logic                        battEn,
  output logic [CODE_W-1:0]           muxSel,
  output logic                        firStart,
  output logic                        cePass,
  output logic                        chopOut,
  output logic                        altFrame,
  output logic                        battMonEn
);
  seqStrobe_t strb;

  mux_seq_ctrl #(
    .NUM_SLOTS      (NUM_SLOTS),
    .TICKS_PER_STATE(TICKS_PER_STATE)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .tickStrobe(tickStrobe),
    .altReq    (altReq),
    .frameLen  (frameLen),
    .strb      (strb),
    .altFrame  (altFrame)
  );

  mux_seq_dp #(
    .NUM_SLOTS(NUM_SLOTS),
    .CODE_W   (CODE_W),
    .BATT_CODE(BATT_CODE)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .regSelVec(regSelVec),
    .altSelVec(altSelVec),
    .chopEn   (chopEn),
    .battEn   (battEn),
    .muxSel   (muxSel),
    .firStart (firStart),
    .cePass   (cePass),
    .chopOut  (chopOut),
    .battMonEn(battMonEn)
  );
endmodule

// File: rtl/mux_seq_chk.sv
module mux_seq_chk #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              tickStrobe,
  input logic              chopEn,
  input logic              battEn,
  input logic [CODE_W-1:0] muxSel,
  input logic              firStart,
  input logic              cePass,
  input logic              chopOut,
  input logic              altFrame,
  input logic              battMonEn
);
  // R2
  sel_moves_on_state_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(muxSel) |-> firStart);

  // R4
  fir_follows_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    firStart |-> $past(tickStrobe));

  // R5
  ce_with_fir_chk: assert property (@(posedge clk) disable iff (rst)
    cePass |-> firStart);

  // R6
  alt_moves_on_frame_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(altFrame) |-> cePass);

  // R8
  chop_off_low_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!chopEn) |-> !chopOut);

  // R9
  batt_gated_chk: assert property (@(posedge clk) disable iff (rst)
    !battEn |-> !battMonEn);
endmodule

bind mux_frame_seq mux_seq_chk #(.CODE_W(CODE_W)) u_chk (.*);

// File: tb/mux_frame_seq_bench.sv
`timescale 1ns/1ps
module mux_frame_seq_bench;
  localparam int NS   = 10;
  localparam int CW   = 4;
  localparam int TK   = 3;
  localparam int BATT = 11;
  localparam int VW   = NS * CW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst, tickStrobe, altReq, chopEn, battEn;
  logic [3:0]    frameLen;
  logic [VW-1:0] regSelVec, altSelVec;
  logic [CW-1:0] muxSel;
  logic          firStart, cePass, chopOut, altFrame, battMonEn;

  mux_frame_seq #(.NUM_SLOTS(NS), .CODE_W(CW), .TICKS_PER_STATE(TK), .BATT_CODE(BATT))
  u_mux_frame_seq (.*);

  int tests = 0, fails = 0;
  bit done = 0;

  // next-cycle stimulus
  bit nStrobe, nAlt, nChop, nBatt;
  int nLen;
  logic [VW-1:0] nReg, nAltBank;

  // bench model
  int mTick, mSlot, mSel;
  bit mPend, mAlt, mChop, mPrev, mFir, mCe;

  // observation counters
  int obsAltFrames, firSinceFrame, lastFrameStates;
  int cyc = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int field(logic [VW-1:0] v, int i);
    return int'((v >> (i*CW)) & VW'(15));
  endfunction

  function automatic int clampLen(int l);
    if (l == 0) return 1;
    if (l > NS) return NS;
    return l;
  endfunction

  task automatic modelReset();
    mTick = 0; mSlot = 0; mSel = 0;
    mPend = 0; mAlt = 0; mChop = 0; mPrev = 0; mFir = 0; mCe = 0;
  endtask

  task automatic modelEdge();
    bit go, frm, edgeA;
    int len, cur;
    len   = clampLen(nLen);
    edgeA = nAlt && !mPrev;
    mPrev = nAlt;
    mFir = 0; mCe = 0; go = 0; frm = 0;
    if (nStrobe) begin
      go = (mTick == 0);
      mTick = (mTick == TK-1) ? 0 : mTick + 1;
    end
    if (go) begin
      frm = (mSlot == 0);
      cur = mSlot;
      mSlot = (mSlot + 1 >= len) ? 0 : mSlot + 1;
      mFir = 1;
      if (frm) begin
        mCe = 1; mAlt = mPend || edgeA; mPend = 0;
      end else if (edgeA) mPend = 1;
      mSel = mAlt ? field(nAltBank, cur) : field(nReg, cur);
    end else if (edgeA) mPend = 1;
    if (!nChop) mChop = 0;
    else if (frm) mChop = !mChop;
  endtask

  task automatic compareAll();
    check(int'(muxSel) == mSel, "R2/R6", "muxSel", int'(muxSel), mSel);
    check(firStart == mFir, "R4", "firStart", int'(firStart), int'(mFir));
    check(cePass == mCe, "R5", "cePass", int'(cePass), int'(mCe));
    check(altFrame == mAlt, "R6", "altFrame", int'(altFrame), int'(mAlt));
    check(chopOut == mChop, "R8", "chopOut", int'(chopOut), int'(mChop));
    check(battMonEn == (battEn && mSel == BATT), "R9", "battMonEn",
          int'(battMonEn), int'(battEn && mSel == BATT));
  endtask

  task automatic step();
    @(negedge clk);
    compareAll();
    if (cePass) begin
      lastFrameStates = firSinceFrame;
      firSinceFrame = 1;
      if (altFrame) obsAltFrames++;
    end else if (firStart) firSinceFrame++;
    tickStrobe = nStrobe; altReq = nAlt; chopEn = nChop; battEn = nBatt;
    frameLen = 4'(nLen); regSelVec = nReg; altSelVec = nAltBank;
    modelEdge();
    cyc++;
  endtask

  task automatic runEven(int n);
    for (int i = 0; i < n; i++) begin
      nStrobe = (cyc % 2 == 0);
      step();
    end
  endtask

  function automatic logic [VW-1:0] randBank();
    logic [VW-1:0] v = '0;
    for (int i = 0; i < NS; i++) v[i*CW +: CW] = CW'($urandom_range(0, 15));
    return v;
  endfunction

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    nStrobe = 0; nAlt = 0; nChop = 0; nBatt = 0; nLen = 10;
    nReg = randBank(); nAltBank = randBank();
    rst = 1; tickStrobe = 0; altReq = 0; chopEn = 0; battEn = 1;
    frameLen = 4'd10; regSelVec = '0; altSelVec = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(muxSel == '0 && !firStart && !cePass && !chopOut && !altFrame && !battMonEn,
          "R1", "reset outputs", int'({muxSel, firStart, cePass, chopOut, altFrame, battMonEn}), 0);
    modelReset();
    rst = 0;
    battEn = 0;
    for (int i = 0; i < 3; i++) step();
    check(muxSel == '0 && !cePass, "R1", "idle before first strobe", int'(muxSel), 0);

    // R3: length clamps
    nChop = 1; nLen = 15; runEven(150);
    check(lastFrameStates == NS, "R3", "states per frame len15", lastFrameStates, NS);
    nLen = 0; runEven(70);
    check(lastFrameStates == 1, "R3", "states per frame len0", lastFrameStates, 1);
    nLen = 7; runEven(100);
    check(lastFrameStates == 7, "R2", "states per frame len7", lastFrameStates, 7);

    // R7: two edges before one boundary
    nLen = 3;
    do runEven(1); while (!(cePass && !altFrame));
    obsAltFrames = 0;
    nAlt = 1; runEven(1); nAlt = 0; runEven(2); nAlt = 1; runEven(1); nAlt = 0;
    runEven(100);
    check(obsAltFrames == 1, "R7", "alt frames after double edge", obsAltFrames, 1);

    // R6: level held high for a long time
    obsAltFrames = 0;
    nAlt = 1; runEven(150); nAlt = 0; runEven(40);
    check(obsAltFrames == 1, "R6", "alt frames for held request", obsAltFrames, 1);

    // R9: battery code selected everywhere, permission toggled
    for (int i = 0; i < NS; i++) nReg[i*CW +: CW] = CW'(BATT);
    nBatt = 0; runEven(60);
    check(!battMonEn, "R9", "battMonEn with permission off", int'(battMonEn), 0);
    nBatt = 1; runEven(60);
    check(battMonEn, "R9", "battMonEn with permission on", int'(battMonEn), 1);

    // random mix
    for (int i = 0; i < 15000; i++) begin
      nStrobe = ($urandom_range(0, 2) == 0);
      if (nAlt) nAlt = ($urandom_range(0, 2) == 0);
      else      nAlt = ($urandom_range(0, 49) == 0);
      if (i % 400 == 0) begin
        nLen = $urandom_range(0, 15);
        nChop = $urandom_range(0, 1);
        nBatt = $urandom_range(0, 1);
        nReg = randBank(); nAltBank = randBank();
      end
      step();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule